// File: doc/BRIEF.md
# LCD Scan and Blink Timer

This block derives the row-scan timing of a multiplexed dot-matrix LCD from a slow source clock of roughly 32 kHz. A prescaler divides the source clock by 1, 2, 4 or 8. Its ticks drive a frame sequencer. The sequencer walks through the active common lines, marks the start of each line and of each frame, and flips an AC-inversion phase at every frame boundary. A long free-running counter supplies a blink phase.

A small merge stage turns the blink phase into lit or dark dots. For a character cell, the glyph dot from the font passes through, or it is replaced by a forced level that the blink pattern selects. For a symbol dot, the dot goes dark during the blink half-period if its blink attribute is set.

A display-off input darkens every output. A standby input does the same and also freezes all counters, so scanning resumes where it stopped.

Top module: `lcd_scan_timer`

## Requirements
- R1: `div_code` selects how many source clocks make one divided tick: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. A frame therefore lasts its tick count multiplied by that ratio, in source clocks.
- R2: A frame lasts 448 divided ticks when `duty_part` is 0 (16 commons) and 468 divided ticks when `duty_part` is 1 (9 commons). `frame_stb` pulses high for one clock at the start of each frame.
- R3: `blink_phase` is bit 14 of a divided-tick counter, so it toggles every 16384 divided ticks and has a full period of 32768 ticks.
- R4: The frame is split evenly across the active commons. `line_stb` pulses once at the start of each line, which gives 16 pulses per frame with 16 commons and 9 with 9 commons. `com_idx` runs from 0 up through the last active common. With 9 commons, indices 9 to 15 are never selected.
- R5: `inv_phase` changes value at every frame start and at no other time.
- R6: When `disp_on` is 0, `com_sel`, `com_valid`, `char_dot_on` and `sym_dot_on` are all 0, while frame and line timing keep running.
- R7: While `standby` is 1, the prescaler and all sequencer state hold still, and the outputs are dark as under R6. Each standby clock lengthens the current frame by exactly one source clock, and `com_idx` keeps its value.
- R8: With `blink_phase` 1 and `char_blink` 1, `char_dot_on` equals `blink_pat`: 1 means every dot lit, 0 means every dot dark. Otherwise `char_dot_on` equals `glyph_dot`.
- R9: `sym_dot_on` is 1 only when `sym_dot` is 1 and it is not the case that both `sym_blink` and `blink_phase` are 1.
- R10: `com_sel` is one-hot on bit `com_idx` while a line is being scanned and the display is shown. Otherwise it is zero.
- R11: While reset is held, `com_idx`, `frame_stb`, `line_stb`, `inv_phase` and `blink_phase` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock (about 32 kHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_part | input | 1 | 1 selects 9 commons, 0 selects 16 |
| div_code | input | 2 | Prescaler ratio code (ratio = 2^code) |
| standby | input | 1 | Freeze all timing and darken the outputs |
| disp_on | input | 1 | Display enable |
| blink_pat | input | 1 | Forced level for blinking characters |
| glyph_dot | input | 1 | Font dot of the current character cell |
| char_blink | input | 1 | Blink attribute of the current character |
| sym_dot | input | 1 | Symbol dot data bit |
| sym_blink | input | 1 | Blink attribute of the symbol dot |
| com_idx | output | 4 | Index of the current common line |
| com_valid | output | 1 | A line is being scanned and shown |
| com_sel | output | 16 | One-hot common select |
| line_stb | output | 1 | One-clock pulse at each line start |
| frame_stb | output | 1 | One-clock pulse at each frame start |
| inv_phase | output | 1 | AC-inversion phase |
| blink_phase | output | 1 | Blink half-period indicator |
| char_dot_on | output | 1 | Merged character dot |
| sym_dot_on | output | 1 | Merged symbol dot |

## Verification
The hardest case to reach is a standby interval that falls in the middle of a frame. At the ports, the only visible proof that the counters froze is a frame exactly as long as the standby stretch added to its normal length.

The stimulus waits for a frame strobe and then enters the frame by a known number of clocks. It holds standby for a fixed count and expects the next frame gap to be 448 plus that count. It also checks that `com_idx` did not move during the stretch.

Dividers above 1 and the 9-common duty are each measured as full frame gaps, after enough settling frames have passed to leave any mixed frame behind. The blink phase needs about 16k clocks per half period, so the merge truth tables are checked on both sides of one real toggle.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    // Common-count mode of the panel
    typedef enum logic {
        DUTY_FULL = 1'b0,
        DUTY_PART = 1'b1
    } duty_e;

endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    input  logic              standby,
    output logic              tick
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t             p_d, p_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        p_d  = p_q;
        lim  = CNT_W'((32'd1 << div_code) - 32'd1);
        tick = !standby && (p_q.cnt >= lim);
        if (!standby) begin
            if (p_q.cnt >= lim) p_d.cnt = '0;
            else                p_d.cnt = p_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // The divider does not advance while standby is held
    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> $stable(p_q.cnt));

    // Any ratio above one spaces the ticks apart
    assert_ratio_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_code != '0 && $stable(div_code)) |=> !tick);

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_scan_pkg::*;
#(
    parameter int FRAME_FULL = 448,
    parameter int FRAME_PART = 468,
    parameter int COMS_FULL  = 16,
    parameter int COMS_PART  = 9,
    parameter int BLINK_LOG2 = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic                         duty_part,
    output logic [$clog2(COMS_FULL)-1:0] com_idx,
    output logic                         scanning,
    output logic                         line_stb,
    output logic                         frame_stb,
    output logic                         inv_phase,
    output logic                         blink_phase
);
    localparam int FRAME_MAX = (FRAME_FULL > FRAME_PART) ? FRAME_FULL : FRAME_PART;
    localparam int POS_W     = $clog2(FRAME_MAX);
    localparam int LINE_FULL = FRAME_FULL / COMS_FULL;
    localparam int LINE_PART = FRAME_PART / COMS_PART;
    localparam int LINE_MAX  = (LINE_FULL > LINE_PART) ? LINE_FULL : LINE_PART;
    localparam int LINE_W    = $clog2(LINE_MAX);
    localparam int COM_W     = $clog2(COMS_FULL);

    typedef struct packed {
        logic [POS_W-1:0]      pos;
        logic [LINE_W-1:0]     line;
        logic [COM_W-1:0]      com;
        logic                  scan;
        logic                  inv;
        logic [BLINK_LOG2-1:0] blink;
        logic                  frame_stb;
        logic                  line_stb;
        duty_e                 duty;
    } seq_t;

    seq_t              s_d, s_q;
    duty_e             duty_in;
    logic [POS_W-1:0]  frame_last;
    logic [LINE_W-1:0] line_last;
    logic [COM_W-1:0]  com_last;

    always_comb begin
        duty_in    = duty_e'(duty_part);
        frame_last = (s_q.duty == DUTY_PART) ? POS_W'(FRAME_PART - 1) : POS_W'(FRAME_FULL - 1);
        line_last  = (s_q.duty == DUTY_PART) ? LINE_W'(LINE_PART - 1) : LINE_W'(LINE_FULL - 1);
        com_last   = (s_q.duty == DUTY_PART) ? COM_W'(COMS_PART - 1)  : COM_W'(COMS_FULL - 1);

        s_d           = s_q;
        s_d.frame_stb = 1'b0;
        s_d.line_stb  = 1'b0;

        if (tick) s_d.blink = s_q.blink + BLINK_LOG2'(1);

        if (duty_in != s_q.duty) begin
            // Mode change restarts the frame quietly
            s_d.duty = duty_in;
            s_d.pos  = '0;
            s_d.line = '0;
            s_d.com  = '0;
            s_d.scan = 1'b1;
        end else if (tick) begin
            if (s_q.pos >= frame_last) begin
                s_d.pos       = '0;
                s_d.line      = '0;
                s_d.com       = '0;
                s_d.scan      = 1'b1;
                s_d.inv       = ~s_q.inv;
                s_d.frame_stb = 1'b1;
                s_d.line_stb  = 1'b1;
            end else begin
                s_d.pos = s_q.pos + POS_W'(1);
                if (s_q.scan) begin
                    if (s_q.line == line_last) begin
                        s_d.line = '0;
                        if (s_q.com == com_last) begin
                            s_d.scan = 1'b0;
                        end else begin
                            s_d.com      = s_q.com + COM_W'(1);
                            s_d.line_stb = 1'b1;
                        end
                    end else begin
                        s_d.line = s_q.line + LINE_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.scan <= 1'b1;
            s_q.duty <= DUTY_FULL;
        end else begin
            s_q <= s_d;
        end
    end

    assign com_idx     = s_q.com;
    assign scanning    = s_q.scan;
    assign line_stb    = s_q.line_stb;
    assign frame_stb   = s_q.frame_stb;
    assign inv_phase   = s_q.inv;
    assign blink_phase = s_q.blink[BLINK_LOG2-1];

    // Index never exceeds the last common of the registered mode
    assert_com_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.com <= com_last);

    // A frame start is also a line start on common zero
    assert_frame_opens_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.frame_stb |-> (s_q.line_stb && s_q.com == '0));

    // Inversion flips exactly at frame starts
    assert_inv_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.inv != $past(s_q.inv)) |-> s_q.frame_stb);

    // Frame position never runs past the frame end
    assert_pos_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(s_q.duty) |-> (s_q.pos <= frame_last));

endmodule

// File: rtl/lcd_blink_merge.sv
module lcd_blink_merge (
    input  logic show,
    input  logic phase,
    input  logic glyph_dot,
    input  logic char_blink,
    input  logic blink_pat,
    input  logic sym_dot,
    input  logic sym_blink,
    output logic char_dot_on,
    output logic sym_dot_on
);
    logic force_char;
    logic hide_sym;

    always_comb begin
        force_char  = char_blink && phase;
        hide_sym    = sym_blink && phase;
        char_dot_on = show && (force_char ? blink_pat : glyph_dot);
        sym_dot_on  = show && sym_dot && !hide_sym;
    end

    // A blinking cell in its alternate half shows the forced level
    always_comb begin
        assert_pattern_R8: assert (!(show && char_blink && phase) || (char_dot_on == blink_pat));
        assert_sym_data_R9: assert (!sym_dot_on || sym_dot);
    end

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_scan_pkg::*;
#(
    parameter int FRAME_FULL = 448,
    parameter int FRAME_PART = 468,
    parameter int COMS_FULL  = 16,
    parameter int COMS_PART  = 9,
    parameter int BLINK_LOG2 = 15,
    parameter int CODE_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         duty_part,
    input  logic [CODE_W-1:0]            div_code,
    input  logic                         standby,
    input  logic                         disp_on,
    input  logic                         blink_pat,
    input  logic                         glyph_dot,
    input  logic                         char_blink,
    input  logic                         sym_dot,
    input  logic                         sym_blink,
    output logic [$clog2(COMS_FULL)-1:0] com_idx,
    output logic                         com_valid,
    output logic [COMS_FULL-1:0]         com_sel,
    output logic                         line_stb,
    output logic                         frame_stb,
    output logic                         inv_phase,
    output logic                         blink_phase,
    output logic                         char_dot_on,
    output logic                         sym_dot_on
);
    localparam int COM_W = $clog2(COMS_FULL);

    logic tick;
    logic scanning;
    logic show;

    assign show = disp_on && !standby;

    lcd_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_code (div_code),
        .standby  (standby),
        .tick     (tick)
    );

    lcd_frame_seq #(
        .FRAME_FULL (FRAME_FULL),
        .FRAME_PART (FRAME_PART),
        .COMS_FULL  (COMS_FULL),
        .COMS_PART  (COMS_PART),
        .BLINK_LOG2 (BLINK_LOG2)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .duty_part   (duty_part),
        .com_idx     (com_idx),
        .scanning    (scanning),
        .line_stb    (line_stb),
        .frame_stb   (frame_stb),
        .inv_phase   (inv_phase),
        .blink_phase (blink_phase)
    );

    lcd_blink_merge u_merge (
        .show        (show),
        .phase       (blink_phase),
        .glyph_dot   (glyph_dot),
        .char_blink  (char_blink),
        .blink_pat   (blink_pat),
        .sym_dot     (sym_dot),
        .sym_blink   (sym_blink),
        .char_dot_on (char_dot_on),
        .sym_dot_on  (sym_dot_on)
    );

    assign com_valid = show && scanning;

    for (genvar i = 0; i < COMS_FULL; i++) begin : g_sel
        assign com_sel[i] = com_valid && (com_idx == COM_W'(i));
    end

    // Every visible output is dark when not shown
    assert_dark_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !show |-> (com_sel == '0 && !char_dot_on && !sym_dot_on));

    // At most one common is driven
    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(com_sel));

    // Short mode leaves the upper commons unselected
    assert_part_upper_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_part && $stable(duty_part)) |-> (com_sel[COMS_FULL-1:COMS_PART] == '0));

endmodule

// File: tb/lcd_scan_timer_test.sv
module lcd_scan_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       duty_part = 1'b0;
    logic [1:0] div_code = 2'd0;
    logic       standby = 1'b0;
    logic       disp_on = 1'b0;
    logic       blink_pat = 1'b0;
    logic       glyph_dot = 1'b0;
    logic       char_blink = 1'b0;
    logic       sym_dot = 1'b0;
    logic       sym_blink = 1'b0;
    logic [3:0] com_idx;
    logic       com_valid;
    logic [15:0] com_sel;
    logic       line_stb, frame_stb, inv_phase, blink_phase, char_dot_on, sym_dot_on;

    lcd_scan_timer uut (
        .clk(clk), .rst_n(rst_n), .duty_part(duty_part), .div_code(div_code),
        .standby(standby), .disp_on(disp_on), .blink_pat(blink_pat),
        .glyph_dot(glyph_dot), .char_blink(char_blink), .sym_dot(sym_dot),
        .sym_blink(sym_blink), .com_idx(com_idx), .com_valid(com_valid),
        .com_sel(com_sel), .line_stb(line_stb), .frame_stb(frame_stb),
        .inv_phase(inv_phase), .blink_phase(blink_phase),
        .char_dot_on(char_dot_on), .sym_dot_on(sym_dot_on)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    typedef struct {
        int len;
        int lines;
        int maxc;
    } exp_t;
    exp_t q[$];

    // Monitor: measures every frame and compares against the queue
    int  last_t = 0;
    bit  last_ok = 0;
    int  lines = 0;
    int  maxc = -1;
    bit  last_inv = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (com_valid && duty_part) chk("R4 short-mode index", (com_idx < 9) ? 1 : 0, 1);
            if (com_valid) chk("R10 one-hot select", int'(com_sel), 1 << com_idx);
            if (frame_stb) begin
                if (last_ok) begin
                    chk("R5 inversion flip", int'(inv_phase != last_inv), 1);
                    if (q.size() != 0) begin
                        exp_t e;
                        e = q.pop_front();
                        chk("R1/R2 frame length", cyc - last_t, e.len);
                        chk("R4 lines per frame", lines, e.lines);
                        chk("R4/R6 highest common", maxc, e.maxc);
                    end
                end
                last_ok  = 1;
                last_t   = cyc;
                last_inv = inv_phase;
                lines    = 1;
                maxc     = com_valid ? int'(com_idx) : -1;
            end else begin
                if (line_stb) lines++;
                if (com_valid && int'(com_idx) > maxc) maxc = int'(com_idx);
            end
        end
    end

    task automatic wait_frame();
        do @(negedge clk); while (!frame_stb);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: configure, settle, then push expected frames
    task automatic run_frames(input int div, input bit part, input bit on, input int n);
        exp_t e;
        @(negedge clk);
        div_code  = 2'(div);
        duty_part = part;
        disp_on   = on;
        repeat (3) wait_frame();
        for (int i = 0; i < n; i++) begin
            e.len   = (part ? 468 : 448) << div;
            e.lines = part ? 9 : 16;
            e.maxc  = on ? (part ? 8 : 15) : -1;
            q.push_back(e);
        end
        drain();
    endtask

    task automatic merge_checks();
        for (int v = 0; v < 8; v++) begin
            glyph_dot  = v[0];
            char_blink = v[1];
            blink_pat  = v[2];
            #1;
            chk("R8 char merge", int'(char_dot_on),
                int'((char_blink && blink_phase) ? blink_pat : glyph_dot));
        end
        for (int v = 0; v < 4; v++) begin
            sym_dot   = v[0];
            sym_blink = v[1];
            #1;
            chk("R9 symbol merge", int'(sym_dot_on),
                int'(sym_dot && !(sym_blink && blink_phase)));
        end
    endtask

    initial begin
        int  c0, t1, t2;
        bit  p, frozen_ok, dark_ok;
        exp_t e;

        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 com_idx", int'(com_idx), 0);
        chk("R11 frame_stb", int'(frame_stb), 0);
        chk("R11 line_stb", int'(line_stb), 0);
        chk("R11 inv_phase", int'(inv_phase), 0);
        chk("R11 blink_phase", int'(blink_phase), 0);
        rst_n = 1'b1;

        // R1, R2, R4: several ratios and both duties
        run_frames(0, 1'b0, 1'b1, 3);
        run_frames(1, 1'b0, 1'b1, 2);
        run_frames(2, 1'b1, 1'b1, 2);
        run_frames(3, 1'b1, 1'b1, 2);

        // R6: display off keeps timing but darkens outputs
        run_frames(0, 1'b0, 1'b0, 2);
        glyph_dot = 1'b1; sym_dot = 1'b1; #1;
        chk("R6 char dark", int'(char_dot_on), 0);
        chk("R6 sym dark", int'(sym_dot_on), 0);
        chk("R6 select dark", int'(com_sel), 0);
        @(negedge clk);
        disp_on = 1'b1;

        // R7: standby in the middle of a frame stretches it exactly
        wait_frame();
        @(negedge clk);
        e.len = 448 + 500; e.lines = 16; e.maxc = 15;
        q.push_back(e);
        repeat (99) @(negedge clk);
        c0 = int'(com_idx);
        standby = 1'b1;
        frozen_ok = 1; dark_ok = 1;
        repeat (500) begin
            @(negedge clk);
            if (int'(com_idx) != c0 || frame_stb || line_stb) frozen_ok = 0;
            if (com_sel != 0 || char_dot_on || sym_dot_on || com_valid) dark_ok = 0;
        end
        chk("R7 state frozen", int'(frozen_ok), 1);
        chk("R7 outputs dark", int'(dark_ok), 1);
        chk("R7 index kept", int'(com_idx), c0);
        standby = 1'b0;
        drain();

        // R3, R8, R9: blink half-period and merge on both phases
        merge_checks();
        p = blink_phase;
        do @(negedge clk); while (blink_phase == p);
        t1 = cyc;
        merge_checks();
        p = blink_phase;
        do @(negedge clk); while (blink_phase == p);
        t2 = cyc;
        chk("R3 blink half-period", t2 - t1, 16384);
        merge_checks();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule